// File: doc/BRIEF.md
# LCD AC-Bias Toggle Generator

This block produces the AC-bias signal of a raster LCD controller. In passive mode the signal is a slow square wave. A down counter reloads from a programmable period field and counts line-clock strobes. Each time the counter runs out, the pin inverts. The panel uses these inversions to swap its supply polarity, so no DC charge builds up on the glass.

A second down counter counts the pin inversions. After a programmable number of them it sets a sticky status bit. The status bit can also drive an interrupt line through an enable input. While the status bit is set, the inversion counter is frozen. It resumes counting only after the processor clears the bit.

In active mode the period field has no effect. The pin then acts as a data-valid enable and follows the pixel-valid input while the controller is enabled. Both counters hold their state in active mode.

Top module: `lcd_acbias_gen`

## Requirements
- R1: After reset, bias_pin, flip_status and irq are all 0.
- R2: While ctl_en is 0, bias_pin is 0 in either mode, and both counters are cleared. The first cycle with ctl_en at 1 loads both counters from the configuration fields. A line strobe in that cycle is not counted.
- R3: In passive mode (mode_active=0) the pin inverts on every (flip_period+1)-th counted line strobe, for any flip_period from 0 to 255. The first inversion after enabling drives the pin to 1.
- R4: In passive mode, bias_pin changes only on the clock edge that samples a line strobe, and it is visible in the following cycle.
- R5: flip_period is sampled only when the counter loads or reloads. A change made mid-count takes effect from the next period.
- R6: With flips_per_irq = N (1 to 15), flip_status becomes 1 on the clock edge of the N-th pin inversion after the counters are loaded.
- R7: While flip_status is 1, pin inversions are not counted. After a clear, flip_status sets again on exactly the N-th following inversion, using the flips_per_irq value sampled when the status was set.
- R8: With flips_per_irq = 0, flip_status never becomes 1.
- R9: If status_clr and a terminal inversion fall in the same cycle, flip_status stays 1. An inversion in the clearing cycle is counted.
- R10: A status_clr pulse without a terminal inversion in the same cycle makes flip_status 0 from the next cycle.
- R11: irq is 1 exactly when flip_status and irq_en are both 1.
- R12: In active mode (mode_active=1) with ctl_en at 1, bias_pin equals pix_valid in the same cycle. Line strobes and flip_period have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| mode_active | input | 1 | 1 = active (data-enable) mode, 0 = passive mode |
| line_stb | input | 1 | Single-cycle line-clock strobe |
| pix_valid | input | 1 | Pixel data is being driven this cycle |
| flip_period | input | 8 | Line strobes per pin inversion, minus one |
| flips_per_irq | input | 4 | Pin inversions per status event, 0 disables |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Processor clear strobe for the status bit |
| bias_pin | output | 1 | AC-bias / data-enable output |
| flip_status | output | 1 | Sticky inversion-count status bit |
| irq | output | 1 | Interrupt request |

## Verification
The checker checks the following on every cycle:
- the pin is low while the controller is disabled;
- in passive mode, the pin moves only after a line strobe;
- in active mode, the pin follows pix_valid;
- the status bit stays set until cleared and rises only after a strobe;
- a plain clear takes effect;
- the interrupt is qualified by its enable.

The exact inversion spacing for each period value needs the bench's sweeps over many strobes. The same holds for:
- the exact inversion count at which the status sets, for each threshold;
- the freeze-and-resume sequence around a clear;
- sampling of the fields only at reload;
- the set-wins collision.

// File: rtl/lcd_acb_pkg.sv
package lcd_acb_pkg;

    localparam int PERIOD_W = 8;
    localparam int IRQCNT_W = 4;

    typedef enum logic {
        BIAS_PASSIVE = 1'b0,
        BIAS_ACTIVE  = 1'b1
    } bias_mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_WRAP = 2'd3
    } cnt_step_e;

    typedef struct packed {
        logic load;
        logic run;
    } seq_ctl_t;

    function automatic cnt_step_e pick_step(input logic load, input logic event_hit,
                                            input logic at_end);
        if (load)
            return STEP_LOAD;
        else if (event_hit && at_end)
            return STEP_WRAP;
        else if (event_hit)
            return STEP_DEC;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/acb_arm_ctrl.sv
module acb_arm_ctrl
    import lcd_acb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_en,
    input  bias_mode_e mode,
    output seq_ctl_t   ctl
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst || !ctl_en)
            armed_q <= 1'b0;
        else
            armed_q <= 1'b1;
    end

    always_comb begin
        ctl.load = ctl_en && !armed_q;
        ctl.run  = ctl_en && armed_q && (mode == BIAS_PASSIVE);
    end
endmodule

// File: rtl/acb_line_divider.sv
module acb_line_divider
    import lcd_acb_pkg::*;
#(
    parameter int CNT_W = PERIOD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_en,
    input  seq_ctl_t         ctl,
    input  logic             line_stb,
    input  logic [CNT_W-1:0] period,
    output logic             tog_pin,
    output logic             flip
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;
    cnt_step_e        step;

    assign at_end = (cnt_q == '0);
    assign step   = pick_step(ctl.load, ctl.run && line_stb, at_end);
    assign flip   = (step == STEP_WRAP);

    always_ff @(posedge clk) begin
        if (rst || !ctl_en) begin
            cnt_q   <= '0;
            tog_pin <= 1'b0;
        end else begin
            unique case (step)
                STEP_LOAD: cnt_q <= period;
                STEP_WRAP: begin
                    cnt_q   <= period;
                    tog_pin <= ~tog_pin;
                end
                STEP_DEC:  cnt_q <= cnt_q - 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/acb_flip_counter.sv
module acb_flip_counter
    import lcd_acb_pkg::*;
#(
    parameter int CNT_W = IRQCNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_en,
    input  seq_ctl_t         ctl,
    input  logic             flip,
    input  logic             status_clr,
    input  logic [CNT_W-1:0] per_irq,
    output logic             status
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             counting;
    logic             hit;
    cnt_step_e        step;

    assign counting = flip && (!status || status_clr);
    // A value of one means the current inversion is the last one.
    // A value of zero means counting is disabled: wrap without setting status.
    assign step = pick_step(ctl.load, counting, (cnt_q == LAST) || (cnt_q == '0));
    assign hit  = (step == STEP_WRAP) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !ctl_en) begin
            cnt_q <= '0;
        end else begin
            unique case (step)
                STEP_LOAD, STEP_WRAP: cnt_q <= per_irq;
                STEP_DEC:             cnt_q <= cnt_q - 1'b1;
                default:              cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (hit)
            status <= 1'b1;
        else if (status_clr)
            status <= 1'b0;
    end
endmodule

// File: rtl/lcd_acbias_gen.sv
module lcd_acbias_gen
    import lcd_acb_pkg::*;
#(
    parameter int P_W = PERIOD_W,
    parameter int I_W = IRQCNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ctl_en,
    input  logic           mode_active,
    input  logic           line_stb,
    input  logic           pix_valid,
    input  logic [P_W-1:0] flip_period,
    input  logic [I_W-1:0] flips_per_irq,
    input  logic           irq_en,
    input  logic           status_clr,
    output logic           bias_pin,
    output logic           flip_status,
    output logic           irq
);
    bias_mode_e mode;
    seq_ctl_t   ctl;
    logic       tog_pin;
    logic       flip;

    assign mode = bias_mode_e'(mode_active);

    acb_arm_ctrl u_arm (
        .clk    (clk),
        .rst    (rst),
        .ctl_en (ctl_en),
        .mode   (mode),
        .ctl    (ctl)
    );

    acb_line_divider #(.CNT_W(P_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ctl_en   (ctl_en),
        .ctl      (ctl),
        .line_stb (line_stb),
        .period   (flip_period),
        .tog_pin  (tog_pin),
        .flip     (flip)
    );

    acb_flip_counter #(.CNT_W(I_W)) u_flips (
        .clk        (clk),
        .rst        (rst),
        .ctl_en     (ctl_en),
        .ctl        (ctl),
        .flip       (flip),
        .status_clr (status_clr),
        .per_irq    (flips_per_irq),
        .status     (flip_status)
    );

    always_comb begin
        if (!ctl_en)
            bias_pin = 1'b0;
        else if (mode == BIAS_ACTIVE)
            bias_pin = pix_valid;
        else
            bias_pin = tog_pin;
    end

    assign irq = flip_status & irq_en;
endmodule

// File: rtl/lcd_acbias_gen_chk.sv
module lcd_acbias_gen_chk (
    input logic clk,
    input logic rst,
    input logic ctl_en,
    input logic mode_active,
    input logic line_stb,
    input logic pix_valid,
    input logic irq_en,
    input logic status_clr,
    input logic bias_pin,
    input logic flip_status,
    input logic irq
);
    p_off_low_r2: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> !bias_pin);

    p_pin_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && !mode_active && !line_stb) |=> (!ctl_en || mode_active || $stable(bias_pin)));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flip_status && !status_clr) |=> flip_status);

    p_status_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flip_status) |-> $past(line_stb));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !line_stb) |=> !flip_status);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flip_status && irq_en));

    p_data_enable_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && mode_active) |-> (bias_pin == pix_valid));
endmodule

bind lcd_acbias_gen lcd_acbias_gen_chk u_chk (.*);

// File: tb/lcd_acbias_gen_bench.sv
module lcd_acbias_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_en = 1'b0;
    logic       mode_active = 1'b0;
    logic       line_stb = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] flip_period = '0;
    logic [3:0] flips_per_irq = '0;
    logic       irq_en = 1'b0;
    logic       status_clr = 1'b0;
    logic       bias_pin, flip_status, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lcd_acbias_gen u_lcd_acbias_gen (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_line();
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
    endtask

    task automatic enable_ctl();
        @(negedge clk) ctl_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic disable_ctl();
        @(negedge clk) ctl_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_status();
        @(negedge clk) status_clr = 1'b1;
        @(negedge clk) status_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int periods[6] = '{0, 1, 2, 3, 5, 255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pin", bias_pin, 0);
        check("R1 status", flip_status, 0);
        check("R1 irq", irq, 0);

        // R2: disabled pin stays low under strobes and pixel valid
        pix_valid = 1'b1;
        pulse_line();
        check("R2 disabled pin", bias_pin, 0);
        pix_valid = 1'b0;

        // R3: sweep of toggle periods
        foreach (periods[i]) begin
            int p = periods[i];
            disable_ctl();
            flip_period = 8'(p);
            enable_ctl();
            for (int s = 1; s <= 3 * (p + 1); s++) begin
                pulse_line();
                check($sformatf("R3 period=%0d strobe=%0d", p, s), bias_pin, (s / (p + 1)) % 2);
            end
        end

        // R4: no strobe, no change
        disable_ctl();
        flip_period = 8'd0;
        enable_ctl();
        pulse_line();
        repeat (10) @(negedge clk);
        check("R4 held pin", bias_pin, 1);
        // R2: disable resets pin
        disable_ctl();
        check("R2 disable clears pin", bias_pin, 0);

        // R2: strobe in load cycle not counted
        flip_period = 8'd1;
        @(negedge clk) begin ctl_en = 1'b1; line_stb = 1'b1; end
        @(negedge clk) line_stb = 1'b0;
        check("R2 load cycle", bias_pin, 0);
        pulse_line();
        check("R2 first counted strobe", bias_pin, 0);
        pulse_line();
        check("R2 second counted strobe", bias_pin, 1);

        // R5: mid-count change takes effect at reload
        disable_ctl();
        flip_period = 8'd3;
        enable_ctl();
        pulse_line();
        flip_period = 8'd0;
        repeat (2) pulse_line();
        check("R5 old period still running", bias_pin, 0);
        pulse_line();
        check("R5 old period ends", bias_pin, 1);
        pulse_line();
        check("R5 new period applied", bias_pin, 0);

        // R6, R7, R8, R10: inversion threshold sweep with one inversion per strobe
        flip_period = 8'd0;
        for (int v = 0; v < 16; v++) begin
            disable_ctl();
            flips_per_irq = 4'(v);
            clear_status();
            enable_ctl();
            for (int s = 1; s <= v + 2; s++) begin
                pulse_line();
                check($sformatf("R6/R8 n=%0d flip=%0d", v, s), flip_status,
                      (v != 0 && s >= v) ? 1 : 0);
            end
            if (v != 0) begin
                clear_status();
                check($sformatf("R10 n=%0d", v), flip_status, 0);
                for (int s = 1; s <= v; s++) begin
                    pulse_line();
                    check($sformatf("R7 n=%0d flip=%0d", v, s), flip_status, (s == v) ? 1 : 0);
                end
            end
        end

        // R9 and R11
        disable_ctl();
        flips_per_irq = 4'd1;
        clear_status();
        enable_ctl();
        pulse_line();
        check("R9 setup", flip_status, 1);
        @(negedge clk) begin line_stb = 1'b1; status_clr = 1'b1; end
        @(negedge clk) begin line_stb = 1'b0; status_clr = 1'b0; end
        check("R9 set wins", flip_status, 1);
        irq_en = 1'b0;
        #1 check("R11 masked", irq, 0);
        irq_en = 1'b1;
        #1 check("R11 enabled", irq, 1);
        clear_status();
        check("R10 clear", flip_status, 0);
        check("R11 cleared", irq, 0);
        irq_en = 1'b0;

        // R12: active mode data enable
        disable_ctl();
        mode_active = 1'b1;
        flip_period = 8'd0;
        enable_ctl();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) begin pix_valid = k[0] ^ k[2]; line_stb = 1'b1; end
            #1 check($sformatf("R12 step=%0d", k), bias_pin, int'(k[0] ^ k[2]));
        end
        @(negedge clk) begin pix_valid = 1'b0; line_stb = 1'b0; end
        #1 check("R12 strobes ignored", bias_pin, 0);
        ctl_en = 1'b0;
        pix_valid = 1'b1;
        #1 check("R2 active disabled", bias_pin, 0);

        finish_run();
    end
endmodule